// File: doc/BRIEF.md
# Multi-Precision Floating-Point Maximum Unit

This unit returns the larger of two IEEE-754 values. It works in half, single or double precision, and a 2-bit format code picks the precision. The first operand arrives as a full 128-bit vector register. The second arrives as its low 64 bits, which is all the widest element needs. The unit compares the low elements, writes the winner into the low element of a 128-bit result, and fills the bits above that element in one of two ways. With merging enabled they are copied from the first operand. With merging disabled they are cleared.

Two mode bits steer the special cases. With the alternate-handling bit clear, the unit follows IEEE rules:

- Negative zero ranks below positive zero.
- A NaN input yields either a propagated quiet NaN or the default NaN of the format, as the default-NaN bit selects.

With the alternate-handling bit set, any NaN input returns the second operand untouched, and so does any pair of zeros. The unit also flags an invalid operation whenever a signaling NaN is present, and it flags an undefined format code.

The result is registered, so it appears one clock after the operands are presented with the input strobe. The output strobe marks the cycle in which it is valid.

Top module: `fpmax_unit`

## Requirements
- R1: The format code selects the element width: 2'b11 is 16-bit half, 2'b00 is 32-bit single and 2'b01 is 64-bit double. Code 2'b10 raises the undefined flag, gives an all-zero result and leaves the invalid flag low.
- R2: The output strobe rises one clock after each input strobe, and the registered result belongs to that input. Reset clears the strobe, the result and both flags.
- R3: For inputs that are not NaN, the result is the larger value under sign-magnitude ordering. Positive beats negative. Among positives the larger magnitude wins, among negatives the smaller magnitude wins, and infinities rank as the extreme values.
- R4: With the alternate bit 0, a comparison of -0 against +0 gives +0 in either operand order.
- R5: With the alternate bit 0 and the default-NaN bit 0, a NaN input gives a quiet NaN. A signaling NaN is preferred over a quiet NaN, and the first operand is preferred over the second. The chosen NaN is returned with the top mantissa bit set.
- R6: With the alternate bit 0 and the default-NaN bit 1, a NaN input gives the default NaN of the format. The values are 16'h7E00 for half, 32'h7FC00000 for single and 64'h7FF8000000000000 for double.
- R7: With the alternate bit 1, a NaN on either input returns the second operand bit for bit, whatever the default-NaN bit holds.
- R8: With the alternate bit 1, when both inputs are zeros of any sign the result is the second operand.
- R9: With the merge input set, the result bits above the element come from the first operand. With the merge input clear, those bits are zero.
- R10: The invalid flag is 1 exactly when either input element is a signaling NaN, in either mode. A signaling NaN has an all-ones exponent, the top mantissa bit 0 and a nonzero mantissa.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op_a | input | 128 | First operand register; low element compared, upper bits used for merging |
| op_b | input | 64 | Low 64 bits of the second operand register |
| fmt_sel | input | 2 | Format code: 11 half, 00 single, 01 double, 10 undefined |
| alt_mode | input | 1 | Alternate zero and NaN handling |
| dflt_nan | input | 1 | Return the default NaN instead of propagating an input NaN |
| merge_en | input | 1 | Keep upper result bits from op_a instead of clearing them |
| out_valid | output | 1 | Registered result is valid |
| result | output | 128 | Maximum in the low element, upper bits merged or zero |
| invalid_flag | output | 1 | A signaling NaN was present |
| undef_fmt | output | 1 | Format code 10 was presented |

## Verification
The assertions check the following on every cycle:

- the one-clock strobe latency;
- the undefined-format flag against the code that was presented;
- the invalid flag against the signaling-NaN status of single-precision inputs;
- the upper-bit handling in half precision;
- the signed-zero and alternate-mode rules in single precision;
- the default NaN in double precision;
- the rule that an ordinary single-precision result is always one of the two operands.

Only the bench scenarios can show the propagation priority among several NaNs, the correct ordering of negative values and infinities across all three widths, and result packing in the single and double formats. The bench does this by comparing every result against its own ordering model.

// File: rtl/fpmax_pkg.sv
package fpmax_pkg;

  localparam int VEC_W      = 128;
  localparam int HALF_EXP_W = 5;
  localparam int HALF_MAN_W = 10;
  localparam int SNGL_EXP_W = 8;
  localparam int SNGL_MAN_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_MAN_W  = 52;
  localparam int MAX_ELEM_W = 1 + DBL_EXP_W + DBL_MAN_W;
  localparam int NUM_FMT    = 3;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_BAD    = 2'b10,
    FMT_HALF   = 2'b11
  } fmt_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fp_class_t;

  // Element width derived from the format code: 8 << (code ^ 2'b10)
  function automatic int elem_width(input logic [1:0] code);
    return 8 << int'(code ^ 2'b10);
  endfunction

  // Index of the lane that serves a legal format code
  function automatic int lane_index(input logic [1:0] code);
    case (code)
      2'b11:   return 0;
      2'b00:   return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/fpmax_classify.sv
module fpmax_classify
  import fpmax_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int ELEM_W = 1 + EXP_W + MAN_W
) (
  input  logic [ELEM_W-1:0] value,
  output fp_class_t         cls,
  output logic [ELEM_W-2:0] mag
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             man_nz;

  assign exp_f    = value[ELEM_W-2 -: EXP_W];
  assign man_f    = value[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign man_nz   = |man_f;

  always_comb begin
    cls.sign    = value[ELEM_W-1];
    cls.is_nan  = exp_ones && man_nz;
    cls.is_snan = exp_ones && man_nz && !man_f[MAN_W-1];
    cls.is_zero = (exp_f == '0) && !man_nz;
  end

  assign mag = value[ELEM_W-2:0];

endmodule

// File: rtl/fpmax_resolve.sv
module fpmax_resolve
  import fpmax_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int ELEM_W = 1 + EXP_W + MAN_W
) (
  input  logic [ELEM_W-1:0] opnd_a,
  input  logic [ELEM_W-1:0] opnd_b,
  input  logic              alt_mode,
  input  logic              dflt_nan,
  output logic [ELEM_W-1:0] elem_out,
  output logic              snan_seen,
  output logic              nan_seen
);

  localparam logic [ELEM_W-1:0] QUIET_BIT   = ELEM_W'(1) << (MAN_W - 1);
  localparam logic [ELEM_W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  fp_class_t         cls_a, cls_b;
  logic [ELEM_W-2:0] mag_a, mag_b;

  fpmax_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .value(opnd_a), .cls(cls_a), .mag(mag_a)
  );
  fpmax_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .value(opnd_b), .cls(cls_b), .mag(mag_b)
  );

  logic              a_wins;
  logic              take_a_nan;
  logic              zero_pair;
  logic [ELEM_W-1:0] larger;
  logic [ELEM_W-1:0] quiet_nan;

  // Sign-magnitude ordering; signs that differ settle it (so +0 beats -0)
  always_comb begin
    if (cls_a.sign != cls_b.sign)
      a_wins = !cls_a.sign;
    else if (cls_a.sign)
      a_wins = mag_a < mag_b;
    else
      a_wins = mag_a > mag_b;
  end

  assign larger     = a_wins ? opnd_a : opnd_b;
  assign take_a_nan = cls_a.is_snan || (!cls_b.is_snan && cls_a.is_nan);
  assign quiet_nan  = (take_a_nan ? opnd_a : opnd_b) | QUIET_BIT;
  assign zero_pair  = cls_a.is_zero && cls_b.is_zero;
  assign nan_seen   = cls_a.is_nan || cls_b.is_nan;
  assign snan_seen  = cls_a.is_snan || cls_b.is_snan;

  always_comb begin
    if (alt_mode) begin
      if (nan_seen || zero_pair) elem_out = opnd_b;
      else                       elem_out = larger;
    end else if (nan_seen) begin
      elem_out = dflt_nan ? DEFAULT_NAN : quiet_nan;
    end else begin
      elem_out = larger;
    end
  end

endmodule

// File: rtl/fpmax_pack.sv
module fpmax_pack #(
  parameter int DATA_W = 128,
  parameter int ELEM_W = 32,
  localparam int UPPER_W = DATA_W - ELEM_W
) (
  input  logic [UPPER_W-1:0] upper_src,
  input  logic [ELEM_W-1:0]  elem,
  input  logic               merge_en,
  output logic [DATA_W-1:0]  packed_out
);

  logic [UPPER_W-1:0] upper_bits;

  assign upper_bits = merge_en ? upper_src : '0;
  assign packed_out = {upper_bits, elem};

endmodule

// File: rtl/fpmax_unit.sv
module fpmax_unit
  import fpmax_pkg::*;
#(
  parameter int DATA_W = VEC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     op_a,
  input  logic [MAX_ELEM_W-1:0] op_b,
  input  logic [1:0]            fmt_sel,
  input  logic                  alt_mode,
  input  logic                  dflt_nan,
  input  logic                  merge_en,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     result,
  output logic                  invalid_flag,
  output logic                  undef_fmt
);

  logic [DATA_W-1:0] lane_result [NUM_FMT];
  logic [NUM_FMT-1:0] lane_snan;
  logic [NUM_FMT-1:0] lane_nan;

  for (genvar k = 0; k < NUM_FMT; k++) begin : g_fmt
    localparam int EXP_W = (k == 0) ? HALF_EXP_W : (k == 1) ? SNGL_EXP_W : DBL_EXP_W;
    localparam int MAN_W = (k == 0) ? HALF_MAN_W : (k == 1) ? SNGL_MAN_W : DBL_MAN_W;
    localparam int EW    = 1 + EXP_W + MAN_W;

    logic [EW-1:0] elem;
    logic          snan_k;
    logic          nan_k;

    fpmax_resolve #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_res (
      .opnd_a   (op_a[EW-1:0]),
      .opnd_b   (op_b[EW-1:0]),
      .alt_mode (alt_mode),
      .dflt_nan (dflt_nan),
      .elem_out (elem),
      .snan_seen(snan_k),
      .nan_seen (nan_k)
    );

    fpmax_pack #(.DATA_W(DATA_W), .ELEM_W(EW)) u_pack (
      .upper_src (op_a[DATA_W-1:EW]),
      .elem      (elem),
      .merge_en  (merge_en),
      .packed_out(lane_result[k])
    );

    assign lane_snan[k] = snan_k;
    assign lane_nan[k]  = nan_k;
  end

  // Named events of the selected lane, brought out for the checker
  logic              sel_undef;
  logic              sel_snan;
  logic              sel_nan;
  logic [DATA_W-1:0] sel_result;

  always_comb begin
    sel_undef  = (fmt_e'(fmt_sel) == FMT_BAD);
    sel_snan   = 1'b0;
    sel_nan    = 1'b0;
    sel_result = '0;
    if (!sel_undef) begin
      sel_snan   = lane_snan[lane_index(fmt_sel)];
      sel_nan    = lane_nan[lane_index(fmt_sel)];
      sel_result = lane_result[lane_index(fmt_sel)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      invalid_flag <= 1'b0;
      undef_fmt    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= sel_result;
        invalid_flag <= sel_snan;
        undef_fmt    <= sel_undef;
      end
    end
  end

endmodule

// File: rtl/fpmax_unit_chk.sv
module fpmax_unit_chk
  import fpmax_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [VEC_W-1:0]      op_a,
  input logic [MAX_ELEM_W-1:0] op_b,
  input logic [1:0]            fmt_sel,
  input logic                  alt_mode,
  input logic                  dflt_nan,
  input logic                  merge_en,
  input logic                  out_valid,
  input logic [VEC_W-1:0]      result,
  input logic                  invalid_flag,
  input logic                  undef_fmt,
  input logic                  sel_nan
);

  function automatic logic nan32(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic logic snan32(input logic [31:0] v);
    return nan32(v) && !v[22];
  endfunction
  function automatic logic zero32(input logic [31:0] v);
    return v[30:0] == 0;
  endfunction
  function automatic logic nan64(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_undef_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (undef_fmt == ($past(fmt_sel) == 2'b10)));

  p_invalid_snan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_sel) == 2'b00) |->
      (invalid_flag == $past(snan32(op_a[31:0]) || snan32(op_b[31:0]))));

  p_merge_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_sel) == 2'b11) |->
      (result[127:16] == ($past(merge_en) ? $past(op_a[127:16]) : 112'd0)));

  p_pos_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_sel == 2'b00 && !alt_mode && zero32(op_a[31:0]) &&
       zero32(op_b[31:0]) && (op_a[31] != op_b[31]))) |-> (result[31:0] == 32'd0));

  p_quiet_prop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_sel == 2'b00 && sel_nan && !alt_mode && !dflt_nan) |=>
      (result[22] && result[30:23] == 8'hFF));

  p_default_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_sel == 2'b01 && !alt_mode && dflt_nan &&
       (nan64(op_a[63:0]) || nan64(op_b)))) |-> (result[63:0] == 64'h7FF8000000000000));

  p_alt_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_sel == 2'b00 && alt_mode &&
       (nan32(op_a[31:0]) || nan32(op_b[31:0])))) |-> (result[31:0] == $past(op_b[31:0])));

  p_alt_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_sel == 2'b00 && alt_mode &&
       zero32(op_a[31:0]) && zero32(op_b[31:0]))) |-> (result[31:0] == $past(op_b[31:0])));

  p_pick_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_sel == 2'b00 && !nan32(op_a[31:0]) && !nan32(op_b[31:0]))) |->
      (result[31:0] == $past(op_a[31:0]) || result[31:0] == $past(op_b[31:0])));

endmodule

bind fpmax_unit fpmax_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .op_a        (op_a),
  .op_b        (op_b),
  .fmt_sel     (fmt_sel),
  .alt_mode    (alt_mode),
  .dflt_nan    (dflt_nan),
  .merge_en    (merge_en),
  .out_valid   (out_valid),
  .result      (result),
  .invalid_flag(invalid_flag),
  .undef_fmt   (undef_fmt),
  .sel_nan     (sel_nan)
);

// File: tb/fpmax_unit_tb.sv
`timescale 1ns/1ps
module fpmax_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0;
  logic [63:0]  op_b = '0;
  logic [1:0]   fmt_sel = 2'b00;
  logic         alt_mode = 1'b0;
  logic         dflt_nan = 1'b0;
  logic         merge_en = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         invalid_flag;
  logic         undef_fmt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [127:0] q_res [$];
  logic         q_inv [$];
  logic         q_und [$];
  string        q_tag [$];

  always #10 clk = ~clk;

  fpmax_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .fmt_sel(fmt_sel), .alt_mode(alt_mode), .dflt_nan(dflt_nan), .merge_en(merge_en),
    .out_valid(out_valid), .result(result), .invalid_flag(invalid_flag),
    .undef_fmt(undef_fmt)
  );

  // Reference model built on an order-preserving key instead of a sign-magnitude compare
  function automatic void model(input logic [127:0] a, input logic [63:0] b,
                                input logic [1:0] f, input logic alt, input logic dn,
                                input logic mg, output logic [127:0] r,
                                output logic inv, output logic und);
    int w, mw;
    logic [63:0] mask, expm, manm, qb, sb, ea, eb, ka, kb, el;
    logic na, nb, sa, sbn, za, zb;
    und = 1'b0; w = 32; mw = 23;
    case (f)
      2'b11: begin w = 16; mw = 10; end
      2'b00: begin w = 32; mw = 23; end
      2'b01: begin w = 64; mw = 52; end
      default: und = 1'b1;
    endcase
    if (und) begin r = '0; inv = 1'b0; return; end
    mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    sb   = 64'd1 << (w - 1);
    manm = (64'd1 << mw) - 1;
    expm = (sb - 1) & ~manm;
    qb   = 64'd1 << (mw - 1);
    ea = a[63:0] & mask;
    eb = b & mask;
    na = ((ea & expm) == expm) && ((ea & manm) != 0);
    nb = ((eb & expm) == expm) && ((eb & manm) != 0);
    sa  = na && ((ea & qb) == 0);
    sbn = nb && ((eb & qb) == 0);
    za = (ea & (sb - 1)) == 0;
    zb = (eb & (sb - 1)) == 0;
    ka = ((ea & sb) != 0) ? (~ea & mask) : (ea | sb);
    kb = ((eb & sb) != 0) ? (~eb & mask) : (eb | sb);
    inv = sa || sbn;
    if (alt && (na || nb || (za && zb))) el = eb;
    else if (na || nb) begin
      if (dn) el = expm | qb;
      else if (sa) el = ea | qb;
      else if (sbn) el = eb | qb;
      else if (na) el = ea | qb;
      else el = eb | qb;
    end else el = (ka >= kb) ? ea : eb;
    r = mg ? a : '0;
    r = r & ~{64'd0, mask};
    r = r | {64'd0, el};
  endfunction

  task automatic drive(input logic [127:0] a, input logic [63:0] b, input logic [1:0] f,
                       input logic alt, input logic dn, input logic mg, input string tag);
    logic [127:0] er;
    logic ei, eu;
    @(negedge clk);
    op_a = a; op_b = b; fmt_sel = f; alt_mode = alt; dflt_nan = dn; merge_en = mg;
    in_valid = 1'b1;
    model(a, b, f, alt, dn, mg, er, ei, eu);
    q_res.push_back(er); q_inv.push_back(ei); q_und.push_back(eu); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q_res.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected output strobe: actual 1 expected 0");
      end else begin
        logic [127:0] er;
        logic ei, eu;
        string tg;
        er = q_res.pop_front(); ei = q_inv.pop_front();
        eu = q_und.pop_front(); tg = q_tag.pop_front();
        if (result !== er || invalid_flag !== ei || undef_fmt !== eu) begin
          errors++;
          $display("FAIL %s result %h inv %b und %b expected %h inv %b und %b",
                   tg, result, invalid_flag, undef_fmt, er, ei, eu);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [127:0] HI = 128'hA5A5_1234_DEAD_BEEF_0F1E_2D3C_0000_0000;

  initial begin : stim
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || invalid_flag !== 1'b0 || undef_fmt !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset state: actual v%b r%h expected 0", out_valid, result);
    end
    rst_n = 1'b1;
    idle(2);

    // R3 ordinary ordering
    drive(128'h3F800000, 64'h40000000, 2'b00, 0, 0, 0, "R3 pos single");
    drive(128'hBF800000, 64'hC0000000, 2'b00, 0, 0, 0, "R3 neg single");
    drive(128'hFF800000, 64'hBF800000, 2'b00, 0, 0, 0, "R3 -inf");
    drive(128'h7F800000, 64'h7F7FFFFF, 2'b00, 0, 0, 0, "R3 +inf");
    drive(128'h3C00, 64'hBC00, 2'b11, 0, 0, 0, "R3 half");
    drive(128'h3FF0000000000000, 64'h4000000000000000, 2'b01, 0, 0, 0, "R3 double");
    drive(128'hC010000000000000, 64'hC000000000000000, 2'b01, 1, 0, 0, "R3 double neg alt");
    // R4 signed zeros
    drive(128'h80000000, 64'h00000000, 2'b00, 0, 0, 0, "R4 -0,+0");
    drive(128'h00000000, 64'h80000000, 2'b00, 0, 0, 0, "R4 +0,-0");
    drive(128'h8000, 64'h0000, 2'b11, 0, 1, 0, "R4 half");
    // R5 propagation order and R10 flag
    drive(128'h7FC00001, 64'h7F800005, 2'b00, 0, 0, 0, "R5 snan b over qnan a");
    drive(128'h7F800001, 64'h7F800002, 2'b00, 0, 0, 0, "R5 snan a first");
    drive(128'h3F800000, 64'h7FC00000, 2'b00, 0, 0, 0, "R5 qnan b");
    drive(128'h7C01, 64'h3C00, 2'b11, 0, 0, 0, "R5 half snan quieted");
    drive(128'hFFF0000000000001, 64'h7FF8000000000007, 2'b01, 0, 0, 0, "R5 double");
    // R6 default NaN
    drive(128'h1234, 64'h7FF0000000000009, 2'b01, 0, 1, 0, "R6 double");
    drive(128'h7E55, 64'h3C00, 2'b11, 0, 1, 0, "R6 half");
    drive(128'h7F800003, 64'h0, 2'b00, 0, 1, 0, "R6 single");
    // R7 and R8 alternate mode
    drive(128'h3F800000, 64'h7F800005, 2'b00, 1, 1, 0, "R7 snan b dn");
    drive(128'h7FC00000, 64'h40400000, 2'b00, 1, 0, 0, "R7 nan a");
    drive(128'hFC01, 64'hFE00, 2'b11, 1, 0, 0, "R7 half");
    drive(128'h00000000, 64'h80000000, 2'b00, 1, 0, 0, "R8 +0,-0");
    drive(128'h80000000, 64'h00000000, 2'b00, 1, 0, 0, "R8 -0,+0");
    drive(128'h8000000000000000, 64'h0, 2'b01, 1, 0, 0, "R8 double");
    // R9 merge and clear
    drive(HI | 128'h3C00, 64'h4000, 2'b11, 0, 0, 1, "R9 half merge");
    drive(HI | 128'h3C00, 64'h4000, 2'b11, 0, 0, 0, "R9 half clear");
    drive(~HI, 64'h40000000, 2'b00, 0, 0, 1, "R9 single merge");
    drive({64'hCAFEF00D_12345678, 64'h1}, 64'h2, 2'b01, 0, 0, 1, "R9 double merge");
    drive({64'hCAFEF00D_12345678, 64'h1}, 64'h2, 2'b01, 0, 0, 0, "R9 double clear");
    // R10 flag in alternate mode
    drive(128'h7F800001, 64'h3F800000, 2'b00, 1, 0, 0, "R10 snan a alt");
    // R1 undefined code
    drive(HI | 128'h7F800001, 64'h1, 2'b10, 0, 0, 1, "R1 undefined");
    drive(128'h1, 64'h2, 2'b01, 0, 0, 0, "R1 after undefined");
    idle(3);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 strobe after idle: actual %b expected 0", out_valid);
    end

    // R3 mixed stress across formats and modes
    for (int i = 0; i < 150; i++) begin
      logic [127:0] a;
      logic [63:0] b;
      logic [1:0] f;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom};
      f = 2'($urandom_range(0, 3));
      if (i % 7 == 0) b[62:52] = 11'h7FF;
      if (i % 5 == 0) a[30:23] = 8'hFF;
      if (i % 9 == 0) a[14:10] = 5'h1F;
      drive(a, b, f, 1'($urandom), 1'($urandom), 1'($urandom), "R3 mixed");
      if (i % 11 == 0) idle(1);
    end
    idle(4);
    checks++;
    if (q_res.size() != 0) begin
      errors++;
      $display("FAIL R2 missing outputs: actual %0d pending expected 0", q_res.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule